// File: doc/BRIEF.md
# Paged Microcode Program Sequencer

This block steps through a microprogram held in an external ROM of 8-bit words, which is divided into 256-word pages. Each cycle it puts a ROM address out and reads back one byte. A byte is taken as three octal digits, with an implied top bit of zero. Most opcodes are one byte long. For these the block emits a one-cycle strobe that carries the opcode, and datapath logic outside the block acts on that strobe. The remaining opcodes take a second byte. They are the long jump to any page, the in-page branches on a selected condition, and the constant load.

The block holds the current page and in-page position. It also owns two registers that the instruction stream writes directly. The first is an 8-bit literal register, which receives the operand byte of every two-byte instruction. The second is an 8-bit counter, which software can load from a data bus, step up or step down. Two reserved branch condition codes use this counter as a one-deep return-address store for subroutine call and return. Reset starts execution at page 0, word 0.

The reset input is asserted asynchronously. Its release passes through a two-stage synchroniser, so execution starts on the third rising clock edge after release.

Top module: `useq_sequencer`

## Requirements
- R1: While reset is active, and until the first fetch, the ROM address is 0, the literal and counter registers are 0, and the strobe is low.
- R2: An opcode is two bytes long when it has bit 7 set (branch), when it is 0o100..0o107 (long jump), or when it is 0o150 (constant load). Every other opcode is one byte. A one-byte opcode takes one cycle. The following address is the in-page position plus one, and it wraps from 0xFF to 0x00 in the same page. In the next cycle op_stb_o is high for exactly one cycle, with op_code_o equal to the opcode. Two-byte opcodes never raise op_stb_o.
- R3: The one-byte opcodes 0o051, 0o052 and 0o053 act on the counter. 0o051 loads bus_i, 0o052 increments modulo 256 and 0o053 decrements modulo 256. The new value appears on cnt_o in the cycle after the opcode fetch.
- R4: Opcode 0o150 copies its second byte into the literal register. Execution then continues at the word that follows that byte.
- R5: A long jump, opcode 0o10P, moves to page P. The in-page position becomes the second byte, and that byte is also copied into the literal register.
- R6: A branch opcode has bits [7:6] = 11 for branch-if-true or 10 for branch-if-false. Bits [5:0] are the condition code, and they index cond_i. When the selected bit equals the sense, the in-page position becomes the second byte and the page does not change.
- R7: When a branch is not taken, execution continues at the word after the second byte, in the same page. Every branch copies its second byte into the literal register, whether or not it is taken.
- R8: Condition code 0o13 is a call. It is taken for either sense and whatever cond_i holds. It writes the in-page address of the word after the call into the counter, then jumps to the second byte.
- R9: Condition code 0o14 is a return. It is taken for either sense and whatever cond_i holds. The in-page position becomes the counter value, the second byte is not used as a target, and the page does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, asynchronous assert, synchronised release |
| rom_addr_o | output | PAGE_W+8 | ROM word address: page in the upper bits, in-page position in the low byte |
| rom_data_i | input | 8 | ROM byte at rom_addr_o, read combinationally in the same cycle |
| cond_i | input | 64 | Condition vector, indexed by a branch's 6-bit condition code |
| bus_i | input | 8 | Data bus, sampled when the counter-load opcode executes |
| lit_o | output | 8 | Literal register |
| cnt_o | output | 8 | Counter / return-address register |
| op_stb_o | output | 1 | One-cycle strobe for each executed one-byte opcode |
| op_code_o | output | 8 | Opcode that goes with op_stb_o |

## Verification
Most internal faults in this block show up on rom_addr_o within one or two cycles. A wrong phase bit makes an operand byte run as an opcode, so the address stops following the expected sequence. A wrong page or in-page value, or a bad branch-sense decode, makes the very next fetch land on the wrong word. A bad return address stays hidden until the matching return executes, so the call/return sequences check the address right after that return. Literal and counter corruption shows directly on lit_o and cnt_o in the cycle after the instruction that writes them.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int BYTE_W   = 8;
  localparam int CC_W     = 6;
  localparam int COND_N   = 1 << CC_W;
  localparam int PFIELD_W = 3;

  localparam logic [BYTE_W-1:0] OP_CONST   = 8'o150;
  localparam logic [BYTE_W-1:0] OP_CNT_LD  = 8'o051;
  localparam logic [BYTE_W-1:0] OP_CNT_INC = 8'o052;
  localparam logic [BYTE_W-1:0] OP_CNT_DEC = 8'o053;
  localparam logic [CC_W-1:0]   CC_CALL    = 6'o13;
  localparam logic [CC_W-1:0]   CC_RET     = 6'o14;

  typedef enum logic [1:0] {K_SINGLE, K_FAR, K_CONST, K_BRANCH} kind_e;
  typedef enum logic [2:0] {C_HOLD, C_LOAD, C_INC, C_DEC, C_SAVE} cnt_cmd_e;
  typedef enum logic {PH_OPC, PH_ARG} phase_e;

  function automatic kind_e classify(input logic [BYTE_W-1:0] b);
    if (b[7])                   return K_BRANCH;
    else if (b[7:3] == 5'b01000) return K_FAR;
    else if (b == OP_CONST)      return K_CONST;
    else                         return K_SINGLE;
  endfunction

endpackage

// File: rtl/useq_decode.sv
module useq_decode
  import useq_pkg::*;
(
  input  phase_e              phase,
  input  logic [BYTE_W-1:0]   rom_byte,
  input  logic [BYTE_W-1:0]   op_q,
  input  logic [COND_N-1:0]   cond_vec,
  output kind_e               fetch_kind,
  output logic                fire_single,
  output logic                br_jump,
  output logic                br_ret,
  output cnt_cmd_e            cnt_cmd
);

  logic            arg_branch;
  logic [CC_W-1:0] cc;
  logic            sense;
  logic            is_call;
  logic            is_ret;

  always_comb begin
    fetch_kind  = classify(rom_byte);
    fire_single = (phase == PH_OPC) && (fetch_kind == K_SINGLE);
    cc          = op_q[CC_W-1:0];
    sense       = op_q[6];
    arg_branch  = (phase == PH_ARG) && (classify(op_q) == K_BRANCH);
    is_call     = arg_branch && (cc == CC_CALL);
    is_ret      = arg_branch && (cc == CC_RET);
    br_ret      = is_ret;
    br_jump     = is_call || (arg_branch && !is_ret && (cond_vec[cc] == sense));

    cnt_cmd = C_HOLD;
    if (is_call) begin
      cnt_cmd = C_SAVE;
    end else if (fire_single) begin
      case (rom_byte)
        OP_CNT_LD:  cnt_cmd = C_LOAD;
        OP_CNT_INC: cnt_cmd = C_INC;
        OP_CNT_DEC: cnt_cmd = C_DEC;
        default:    cnt_cmd = C_HOLD;
      endcase
    end
  end

endmodule

// File: rtl/useq_pc.sv
module useq_pc
  import useq_pkg::*;
#(
  parameter int PAGE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic [BYTE_W-1:0] op_q,
  input  logic [BYTE_W-1:0] rom_byte,
  input  logic              br_jump,
  input  logic              br_ret,
  input  logic [BYTE_W-1:0] cnt_q,
  output logic [PAGE_W-1:0] page_q,
  output logic [BYTE_W-1:0] pos_q
);

  logic [PAGE_W-1:0] far_page;
  logic [PAGE_W-1:0] page_d;
  logic [BYTE_W-1:0] pos_d;

  generate
    if (PAGE_W > PFIELD_W) begin : g_wide
      assign far_page = {{(PAGE_W-PFIELD_W){1'b0}}, op_q[PFIELD_W-1:0]};
    end else begin : g_narrow
      assign far_page = op_q[PAGE_W-1:0];
    end
  endgenerate

  always_comb begin
    page_d = page_q;
    pos_d  = pos_q + 8'd1;
    if (phase == PH_ARG) begin
      case (classify(op_q))
        K_FAR: begin
          page_d = far_page;
          pos_d  = rom_byte;
        end
        K_BRANCH: begin
          if (br_ret)       pos_d = cnt_q;
          else if (br_jump) pos_d = rom_byte;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      pos_q  <= '0;
    end else begin
      page_q <= page_d;
      pos_q  <= pos_d;
    end
  end

endmodule

// File: rtl/useq_counter.sv
module useq_counter
  import useq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_n,
  input  cnt_cmd_e          cmd,
  input  logic [BYTE_W-1:0] bus,
  input  logic [BYTE_W-1:0] save_val,
  output logic [BYTE_W-1:0] cnt_q
);

  logic [BYTE_W-1:0] cnt_d;
  logic              cnt_en;

  always_comb begin
    cnt_en = (cmd != C_HOLD);
    case (cmd)
      C_LOAD:  cnt_d = bus;
      C_INC:   cnt_d = cnt_q + 8'd1;
      C_DEC:   cnt_d = cnt_q - 8'd1;
      C_SAVE:  cnt_d = save_val;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int PAGE_W = 3,
  localparam int ADDR_W = PAGE_W + BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] rom_addr_o,
  input  logic [BYTE_W-1:0] rom_data_i,
  input  logic [COND_N-1:0] cond_i,
  input  logic [BYTE_W-1:0] bus_i,
  output logic [BYTE_W-1:0] lit_o,
  output logic [BYTE_W-1:0] cnt_o,
  output logic              op_stb_o,
  output logic [BYTE_W-1:0] op_code_o
);

  logic rst_meta, rst_sync;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  phase_e            phase_q, phase_d;
  logic [BYTE_W-1:0] op_q, lit_q, code_q;
  logic              stb_q;
  logic              op_en, lit_en;

  kind_e             fetch_kind;
  logic              fire_single, br_jump, br_ret;
  cnt_cmd_e          cnt_cmd;
  logic [PAGE_W-1:0] page_q;
  logic [BYTE_W-1:0] pos_q;
  logic [BYTE_W-1:0] cnt_q;

  useq_decode u_dec (
    .phase       (phase_q),
    .rom_byte    (rom_data_i),
    .op_q        (op_q),
    .cond_vec    (cond_i),
    .fetch_kind  (fetch_kind),
    .fire_single (fire_single),
    .br_jump     (br_jump),
    .br_ret      (br_ret),
    .cnt_cmd     (cnt_cmd)
  );

  useq_pc #(.PAGE_W(PAGE_W)) u_pc (
    .clk_i    (clk_i),
    .rst_n    (rst_sync),
    .phase    (phase_q),
    .op_q     (op_q),
    .rom_byte (rom_data_i),
    .br_jump  (br_jump),
    .br_ret   (br_ret),
    .cnt_q    (cnt_q),
    .page_q   (page_q),
    .pos_q    (pos_q)
  );

  useq_counter u_cnt (
    .clk_i    (clk_i),
    .rst_n    (rst_sync),
    .cmd      (cnt_cmd),
    .bus      (bus_i),
    .save_val (pos_q + 8'd1),
    .cnt_q    (cnt_q)
  );

  always_comb begin
    op_en   = (phase_q == PH_OPC) && (fetch_kind != K_SINGLE);
    lit_en  = (phase_q == PH_ARG);
    phase_d = op_en ? PH_ARG : PH_OPC;
  end

  always_ff @(posedge clk_i or negedge rst_sync) begin
    if (!rst_sync) begin
      phase_q <= PH_OPC;
      op_q    <= '0;
      lit_q   <= '0;
      stb_q   <= 1'b0;
      code_q  <= '0;
    end else begin
      phase_q <= phase_d;
      stb_q   <= fire_single;
      if (op_en)       op_q   <= rom_data_i;
      if (lit_en)      lit_q  <= rom_data_i;
      if (fire_single) code_q <= rom_data_i;
    end
  end

  assign rom_addr_o = {page_q, pos_q};
  assign lit_o      = lit_q;
  assign cnt_o      = cnt_q;
  assign op_stb_o   = stb_q;
  assign op_code_o  = code_q;

endmodule

// File: rtl/useq_sequencer_chk.sv
module useq_sequencer_chk
  import useq_pkg::*;
#(
  parameter int PAGE_W = 3,
  localparam int ADDR_W = PAGE_W + BYTE_W
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic [ADDR_W-1:0] rom_addr_o,
  input logic [BYTE_W-1:0] rom_data_i,
  input logic [BYTE_W-1:0] lit_o,
  input logic [BYTE_W-1:0] cnt_o,
  input logic              op_stb_o,
  input logic [BYTE_W-1:0] op_code_o,
  input phase_e            phase_q,
  input logic [BYTE_W-1:0] op_q
);

  logic              past_ok;
  logic [ADDR_W-1:0] seq_next;
  logic              in_arg, in_opc;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assign seq_next = {rom_addr_o[ADDR_W-1:BYTE_W], rom_addr_o[BYTE_W-1:0] + 8'd1};
  assign in_arg   = past_ok && (phase_q == PH_ARG);
  assign in_opc   = past_ok && (phase_q == PH_OPC);

  a_r2_single_advance: assert property (@(posedge clk_i) disable iff (!rst_n)
    in_opc && classify(rom_data_i) == K_SINGLE |=> rom_addr_o == $past(seq_next));

  a_r2_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_n)
    in_opc && classify(rom_data_i) == K_SINGLE |=> op_stb_o && op_code_o == $past(rom_data_i));

  a_r2_no_strobe_operand: assert property (@(posedge clk_i) disable iff (!rst_n)
    in_arg |-> !op_stb_o);

  a_r4_const_load: assert property (@(posedge clk_i) disable iff (!rst_n)
    in_arg && classify(op_q) == K_CONST |=> lit_o == $past(rom_data_i) && rom_addr_o == $past(seq_next));

  a_r5_far_target: assert property (@(posedge clk_i) disable iff (!rst_n)
    in_arg && classify(op_q) == K_FAR |=>
      rom_addr_o[BYTE_W-1:0] == $past(rom_data_i) && lit_o == $past(rom_data_i));

  a_r7_branch_same_page: assert property (@(posedge clk_i) disable iff (!rst_n)
    in_arg && classify(op_q) == K_BRANCH |=> $stable(rom_addr_o[ADDR_W-1:BYTE_W]));

  a_r8_call_saves: assert property (@(posedge clk_i) disable iff (!rst_n)
    in_arg && classify(op_q) == K_BRANCH && op_q[CC_W-1:0] == CC_CALL |=>
      cnt_o == $past(rom_addr_o[BYTE_W-1:0]) + 8'd1 && rom_addr_o[BYTE_W-1:0] == $past(rom_data_i));

  a_r9_ret_restores: assert property (@(posedge clk_i) disable iff (!rst_n)
    in_arg && classify(op_q) == K_BRANCH && op_q[CC_W-1:0] == CC_RET |=>
      rom_addr_o[BYTE_W-1:0] == $past(cnt_o));

endmodule

bind useq_sequencer useq_sequencer_chk #(.PAGE_W(PAGE_W)) chk_i (
  .clk_i      (clk_i),
  .rst_n      (rst_sync),
  .rom_addr_o (rom_addr_o),
  .rom_data_i (rom_data_i),
  .lit_o      (lit_o),
  .cnt_o      (cnt_o),
  .op_stb_o   (op_stb_o),
  .op_code_o  (op_code_o),
  .phase_q    (phase_q),
  .op_q       (op_q)
);

// File: tb/useq_sequencer_tb_top.sv
module useq_sequencer_tb_top;
  import useq_pkg::*;

  localparam int PAGE_W = 3;
  localparam int ADDR_W = PAGE_W + BYTE_W;
  localparam int ROM_N  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] rom_addr;
  logic [BYTE_W-1:0] rom_data;
  logic [COND_N-1:0] cond;
  logic [BYTE_W-1:0] bus;
  logic [BYTE_W-1:0] lit, cnt, code;
  logic              stb;
  logic [BYTE_W-1:0] rom [ROM_N];

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  assign rom_data = rom[rom_addr];

  useq_sequencer #(.PAGE_W(PAGE_W)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .rom_addr_o (rom_addr),
    .rom_data_i (rom_data),
    .cond_i     (cond),
    .bus_i      (bus),
    .lit_o      (lit),
    .cnt_o      (cnt),
    .op_stb_o   (stb),
    .op_code_o  (code)
  );

  always #2.5ns clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart();
    @(negedge clk);
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(2);
  endtask

  function automatic logic two_byte(input logic [7:0] v);
    return v[7] || (v[7:3] == 5'b01000) || (v == 8'o150);
  endfunction

  function automatic logic [ADDR_W-1:0] at(input int page, input int pos);
    return ADDR_W'(page * 256 + pos);
  endfunction

  initial begin
    rst_n = 1'b0;
    cond  = '0;
    bus   = '0;
    for (int i = 0; i < ROM_N; i++) rom[i] = 8'o000;

    // R1: state held during reset and up to the first fetch
    step(3);
    check("R1", "addr in reset", int'(rom_addr), 0);
    check("R1", "strobe in reset", int'(stb), 0);
    rom[0] = 8'o001;
    restart();
    check("R1", "addr", int'(rom_addr), 0);
    check("R1", "lit", int'(lit), 0);
    check("R1", "cnt", int'(cnt), 0);
    check("R1", "strobe", int'(stb), 0);

    // R2/R3/R4: sweep every first opcode
    for (int v = 0; v < 256; v++) begin
      logic [7:0] opb;
      int exp_cnt;
      opb = 8'(v);
      rom[0] = opb;
      rom[1] = 8'o150;
      rom[2] = 8'h5A;
      bus = 8'hC3;
      restart();
      step(1);
      check("R2", "strobe vs length", int'(stb), two_byte(opb) ? 0 : 1);
      if (!two_byte(opb)) begin
        check("R2", "opcode on strobe", int'(code), v);
        check("R2", "next addr", int'(rom_addr), 1);
        exp_cnt = (opb == 8'o051) ? 'hC3 : (opb == 8'o052) ? 1 : (opb == 8'o053) ? 'hFF : 0;
        check("R3", "counter op", int'(cnt), exp_cnt);
        step(1);
        check("R2", "strobe one cycle", int'(stb), 0);
        step(1);
        check("R4", "const lit", int'(lit), 'h5A);
        check("R4", "addr after const", int'(rom_addr), 3);
      end
    end

    // R3: counter chain with wrap both ways
    rom[0] = 8'o051; rom[1] = 8'o053; rom[2] = 8'o053; rom[3] = 8'o052; rom[4] = 8'o052;
    bus = 8'h00;
    restart();
    step(1); check("R3", "load 0", int'(cnt), 0);
    step(1); check("R3", "dec wrap", int'(cnt), 'hFF);
    step(1); check("R3", "dec", int'(cnt), 'hFE);
    step(1); check("R3", "inc", int'(cnt), 'hFF);
    step(1); check("R3", "inc wrap", int'(cnt), 0);

    // R5: long jump to every page
    for (int p = 0; p < 8; p++) begin
      rom[0] = 8'o100 | 8'(p);
      rom[1] = 8'(64 + p);
      restart();
      step(1);
      check("R5", "operand fetch addr", int'(rom_addr), 1);
      check("R5", "no strobe", int'(stb), 0);
      step(1);
      check("R5", "far target", int'(rom_addr), p * 256 + 64 + p);
      check("R5", "lit gets target", int'(lit), 64 + p);
    end

    // R2: in-page wrap
    rom[0] = 8'o102; rom[1] = 8'hFF;
    rom[at(2, 255)] = 8'o001; rom[at(2, 0)] = 8'o002;
    restart();
    step(2);
    check("R2", "at page end", int'(rom_addr), 2 * 256 + 255);
    step(1);
    check("R2", "wrap in page", int'(rom_addr), 2 * 256);
    check("R2", "wrap opcode", int'(code), 1);

    // R6/R7: every ordinary condition code, both senses, both values
    for (int cc = 0; cc < 64; cc++) begin
      if (cc == 11 || cc == 12) continue;
      for (int s = 0; s < 2; s++) begin
        for (int val = 0; val < 2; val++) begin
          logic taken;
          rom[0] = 8'o103; rom[1] = 8'h10;
          rom[at(3, 16)] = {(s != 0) ? 2'b11 : 2'b10, 6'(cc)};
          rom[at(3, 17)] = 8'h80;
          cond = (val != 0) ? (64'd1 << cc) : ~(64'd1 << cc);
          taken = (val == s);
          restart();
          step(3);
          check("R6", "branch operand addr", int'(rom_addr), 3 * 256 + 17);
          check("R6", "no strobe on branch", int'(stb), 0);
          step(1);
          if (taken) check("R6", "taken target", int'(rom_addr), 3 * 256 + 'h80);
          else       check("R7", "fall through", int'(rom_addr), 3 * 256 + 18);
          check("R7", "branch lit", int'(lit), 'h80);
        end
      end
    end

    // R8/R9: call and return, any sense, any condition vector
    for (int s = 0; s < 2; s++) begin
      for (int cv = 0; cv < 2; cv++) begin
        rom[0] = 8'o101; rom[1] = 8'h20;
        rom[at(1, 32)] = {(s != 0) ? 2'b11 : 2'b10, 6'o13};
        rom[at(1, 33)] = 8'h50;
        rom[at(1, 80)] = {(s != 0) ? 2'b10 : 2'b11, 6'o14};
        rom[at(1, 81)] = 8'h99;
        rom[at(1, 34)] = 8'o001;
        cond = (cv != 0) ? '1 : '0;
        restart();
        step(2);
        check("R8", "at call", int'(rom_addr), 256 + 32);
        step(2);
        check("R8", "call target", int'(rom_addr), 256 + 80);
        check("R8", "saved return", int'(cnt), 'h22);
        check("R8", "call lit", int'(lit), 'h50);
        step(2);
        check("R9", "return addr", int'(rom_addr), 256 + 34);
        check("R9", "return lit", int'(lit), 'h99);
        check("R9", "counter kept", int'(cnt), 'h22);
      end
    end

    // R9: return to a loaded counter value, operand ignored
    bus = 8'h37;
    rom[0] = 8'o051; rom[1] = 8'o314; rom[2] = 8'hAB;
    restart();
    step(1);
    check("R3", "load from bus", int'(cnt), 'h37);
    step(2);
    check("R9", "return to counter", int'(rom_addr), 'h37);
    check("R9", "operand to lit only", int'(lit), 'hAB);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule